// File: doc/BRIEF.md
# Protection Identifier Matcher

This block decides which kinds of access (read, write, execute) a page allows, judged only by protection identifiers. A page carries an access identifier; the processor holds four protection-ID registers. On a request strobe the block compares the page identifier against the ID fields in those registers and returns a 3-bit rights mask together with a flag telling whether some field matched. Privilege-level checks and fault encoding are left to the surrounding logic.

In narrow mode each register holds one ID field, in its lower 32 bits. In wide mode each 64-bit register holds two independent fields, one per 32-bit half. The lowest bit of every field is a write-disable flag. When it is set, a match grants only read and execute. An access identifier of zero marks a public page. Such a page gets full rights and no comparison is made. The result is registered and appears one cycle after the request, marked by a one-cycle done pulse.

Top module: `pidm_matcher`

## Requirements
- R1: `done` is high in exactly the cycle after a cycle in which `req` was high, and low otherwise.
- R2: A field matches when bits [15:0] of `access_id` equal the field's bits [16:1]. For the lower half of register k these are `pid_regs` bits [64k+16 : 64k+1]. For the upper half they are bits [64k+48 : 64k+33].
- R3: Rights encoding: bit 0 is read, bit 1 is write, bit 2 is execute. A match on a field whose bit 0 (bit 64k or 64k+32) is set gives 3'b101. A match on a field whose bit 0 is clear gives 3'b111. In both cases `match` is 1.
- R4: When several fields match, the first one in this order decides: register 0 lower, register 0 upper, register 1 lower, register 1 upper, and so on up to register 3 upper.
- R5: Upper-half fields take part only while `wide` is 1. While `wide` is 0 an upper-half key that equals the identifier has no effect.
- R6: If no enabled field matches a non-zero `access_id`, `rights` is 3'b000 and `match` is 0.
- R7: An `access_id` of exactly zero gives `rights` 3'b111 and `match` 0. A non-zero identifier whose low 16 bits are zero is not public and is compared like any other.
- R8: `rights` and `match` keep their values while `req` is low. Input changes without a request have no effect on them.
- R9: After reset `rights`, `match` and `done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request strobe; evaluates the current inputs |
| wide | input | 1 | 1: two ID fields per register; 0: one field per register |
| access_id | input | 32 | Page access identifier |
| pid_regs | input | 256 | Four 64-bit protection-ID registers; register k in bits [64k+63:64k] |
| rights | output | 3 | Allowed accesses: bit 0 read, bit 1 write, bit 2 execute |
| match | output | 1 | An ID field matched |
| done | output | 1 | One-cycle pulse: result valid |

## Verification
Directed cases come first.
- A zero identifier next to a non-zero identifier with zero low bits separates the public-page shortcut from an ordinary compare.
- Identical keys placed in several registers and halves, with differing write-disable bits, show which field wins.
- The same upper-half key is applied with `wide` set and then cleared, so any leak of the upper halves into narrow mode shows up.

A random sweep then draws keys from a tiny range, so that multiple and absent matches are both frequent. The random junk above bit 16 of each half must be ignored by the compare.

// File: rtl/pidm_pkg.sv
package pidm_pkg;

  typedef logic [2:0] rights_t;

  localparam rights_t RIGHTS_NONE = 3'b000;
  localparam rights_t RIGHTS_RX   = 3'b101;
  localparam rights_t RIGHTS_RWX  = 3'b111;

  // Rights granted by a hit, given the field's write-disable flag.
  function automatic rights_t hit_rights(input logic wr_dis);
    return wr_dis ? RIGHTS_RX : RIGHTS_RWX;
  endfunction

  // Final result selection: public page, hit, or miss.
  function automatic rights_t pick_rights(input logic is_public, input logic any_hit,
                                          input logic wr_dis);
    if (is_public) return RIGHTS_RWX;
    if (any_hit)   return hit_rights(wr_dis);
    return RIGHTS_NONE;
  endfunction

endpackage

// File: rtl/pidm_field_cmp.sv
module pidm_field_cmp #(
  parameter int FIELD_W = 32,
  parameter int ID_W    = 16,
  parameter int AID_W   = 32
) (
  input  logic               enable,
  input  logic [AID_W-1:0]   access_id,
  input  logic [FIELD_W-1:0] field,
  output logic               hit,
  output logic               wr_dis
);
  logic [ID_W-1:0] key;

  assign key    = field[ID_W:1];
  assign wr_dis = field[0];
  assign hit    = enable && (access_id[ID_W-1:0] == key);
endmodule

// File: rtl/pidm_prio_sel.sv
module pidm_prio_sel #(
  parameter int N = 8
) (
  input  logic [N-1:0] hit_vec,
  input  logic [N-1:0] wd_vec,
  output logic [N-1:0] sel_vec,
  output logic         any_hit,
  output logic         sel_wd
);
  logic [N:0] blocked;

  assign blocked[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign sel_vec[i]   = hit_vec[i] & ~blocked[i];
    assign blocked[i+1] = blocked[i] | hit_vec[i];
  end

  assign any_hit = blocked[N];
  assign sel_wd  = |(sel_vec & wd_vec);
endmodule

// File: rtl/pidm_matcher.sv
module pidm_matcher #(
  parameter int NREG  = 4,
  parameter int REG_W = 64,
  parameter int ID_W  = 16,
  parameter int AID_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req,
  input  logic                  wide,
  input  logic [AID_W-1:0]      access_id,
  input  logic [NREG*REG_W-1:0] pid_regs,
  output logic [2:0]            rights,
  output logic                  match,
  output logic                  done
);
  import pidm_pkg::*;

  localparam int HALF_W = REG_W / 2;
  localparam int NFLD   = NREG * 2;

  logic [NFLD-1:0] hit_vec;
  logic [NFLD-1:0] wd_vec;
  logic [NFLD-1:0] sel_vec;
  logic            any_hit;
  logic            sel_wd;
  logic            is_public;
  rights_t         nxt_rights;
  logic            nxt_match;
  rights_t         rights_q;
  logic            match_q;
  logic            done_q;

  // Field order r*2+h: lower half of each register before its upper half.
  for (genvar r = 0; r < NREG; r++) begin : g_reg
    for (genvar h = 0; h < 2; h++) begin : g_half
      pidm_field_cmp #(
        .FIELD_W(HALF_W),
        .ID_W   (ID_W),
        .AID_W  (AID_W)
      ) u_cmp (
        .enable   ((h == 0) ? 1'b1 : wide),
        .access_id(access_id),
        .field    (pid_regs[r*REG_W + h*HALF_W +: HALF_W]),
        .hit      (hit_vec[r*2+h]),
        .wr_dis   (wd_vec[r*2+h])
      );
    end
  end

  pidm_prio_sel #(.N(NFLD)) u_sel (
    .hit_vec(hit_vec),
    .wd_vec (wd_vec),
    .sel_vec(sel_vec),
    .any_hit(any_hit),
    .sel_wd (sel_wd)
  );

  assign is_public  = (access_id == '0);
  assign nxt_rights = pick_rights(is_public, any_hit, sel_wd);
  assign nxt_match  = !is_public && any_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rights_q <= RIGHTS_NONE;
      match_q  <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= req;
      if (req) begin
        rights_q <= nxt_rights;
        match_q  <= nxt_match;
      end
    end
  end

  assign rights = rights_q;
  assign match  = match_q;
  assign done   = done_q;
endmodule

// File: rtl/pidm_checker.sv
module pidm_checker #(
  parameter int NFLD  = 8,
  parameter int AID_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req,
  input logic             wide,
  input logic [AID_W-1:0] access_id,
  input logic [2:0]       rights,
  input logic             match,
  input logic             done,
  input logic [NFLD-1:0]  hit_vec,
  input logic [NFLD-1:0]  sel_vec
);
  logic [NFLD-1:0] upper_mask;
  always_comb begin
    upper_mask = '0;
    for (int i = 1; i < NFLD; i += 2) upper_mask[i] = 1'b1;
  end

  a_r1_done_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> done);
  a_r1_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !done);
  a_r7_public_full: assert property (@(posedge clk) disable iff (!rst_n)
    (req && access_id == '0) |=> (rights == 3'b111 && !match));
  a_r3_match_keeps_rx: assert property (@(posedge clk) disable iff (!rst_n)
    (done && match) |-> (rights[0] && rights[2]));
  a_r6_miss_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (req && access_id != '0 && hit_vec == '0) |=> (rights == 3'b000 && !match));
  a_r4_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_vec));
  a_r4_winner_is_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_vec & ~hit_vec) == '0);
  a_r5_narrow_upper_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !wide |-> (hit_vec & upper_mask) == '0);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> ($stable(rights) && $stable(match)));
endmodule

bind pidm_matcher pidm_checker #(.NFLD(NREG*2), .AID_W(AID_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req      (req),
  .wide     (wide),
  .access_id(access_id),
  .rights   (rights),
  .match    (match),
  .done     (done),
  .hit_vec  (hit_vec),
  .sel_vec  (sel_vec)
);

// File: tb/pidm_matcher_tb.sv
module pidm_matcher_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req = 1'b0;
  logic         wide = 1'b0;
  logic [31:0]  access_id = '0;
  logic [255:0] pid_regs = '0;
  logic [2:0]   rights;
  logic         match;
  logic         done;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pidm_matcher u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .wide(wide), .access_id(access_id),
    .pid_regs(pid_regs), .rights(rights), .match(match), .done(done)
  );

  // One register: lower key in [16:1], lower wd in [0]; upper key in [48:33], upper wd in [32].
  function automatic logic [63:0] mk_reg(input logic [15:0] klo, input logic wlo,
                                         input logic [15:0] khi, input logic whi,
                                         input logic [63:0] junk);
    logic [63:0] v = junk;
    v[16:1]  = klo; v[0]  = wlo;
    v[48:33] = khi; v[32] = whi;
    return v;
  endfunction

  // Reference: returns {match, rights}.
  function automatic logic [3:0] model(input logic [31:0] aid, input logic w,
                                       input logic [255:0] regs);
    if (aid == 0) return 4'b0111;
    for (int r = 0; r < 4; r++) begin
      for (int h = 0; h < 2; h++) begin
        logic [63:0] rv = regs[r*64 +: 64];
        logic [31:0] f  = rv >> (32 * h);
        if (h == 1 && !w) continue;
        if ((f >> 1) % 65536 == aid % 65536) return f[0] ? 4'b1101 : 4'b1111;
      end
    end
    return 4'b0000;
  endfunction

  task automatic check(input string tag, input logic [2:0] er, input logic em,
                       input logic ed);
    checks++;
    if (rights !== er || match !== em || done !== ed) begin
      errors++;
      $display("FAIL %s: rights=%b match=%b done=%b expected rights=%b match=%b done=%b",
               tag, rights, match, done, er, em, ed);
    end
  endtask

  task automatic run(input string tag, input logic [31:0] aid, input logic w,
                     input logic [255:0] regs, input logic [2:0] er, input logic em);
    @(negedge clk);
    access_id = aid; wide = w; pid_regs = regs; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    check(tag, er, em, 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not end, actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [255:0] regs;
    repeat (3) @(negedge clk);
    check("R9 reset", 3'b000, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 after reset release", 3'b000, 1'b0, 1'b0);

    // R7: public page, even though every key is zero
    run("R7 public", 32'h0, 1'b1, '0, 3'b111, 1'b0);
    @(negedge clk);
    check("R1 done single pulse", 3'b111, 1'b0, 1'b0);

    // R7/R2: high bits set, low 16 zero -> compared against key 0
    regs = '0; regs[63:0] = mk_reg(16'h0, 1'b1, 16'h0, 1'b0, '0);
    run("R7 nonpublic zero low", 32'h0001_0000, 1'b0, regs, 3'b101, 1'b1);

    // R2/R3: register 2 lower, both write-disable values
    regs = '0; regs[128 +: 64] = mk_reg(16'h0005, 1'b0, 16'h0, 1'b0, 64'hFFF0_0000_FFF0_0000);
    run("R2 R3 rwx", 32'h0005, 1'b0, regs, 3'b111, 1'b1);
    regs[128] = 1'b1;
    run("R3 rx", 32'h0005, 1'b0, regs, 3'b101, 1'b1);

    // R4: register 1 before register 3
    regs = '0;
    regs[64 +: 64]  = mk_reg(16'h0007, 1'b1, 16'h0, 1'b0, '0);
    regs[192 +: 64] = mk_reg(16'h0007, 1'b0, 16'h0, 1'b0, '0);
    run("R4 reg order", 32'h0007, 1'b0, regs, 3'b101, 1'b1);

    // R4/R5: register 0 upper precedes register 1 lower in wide mode
    regs = '0;
    regs[0 +: 64]  = mk_reg(16'h0001, 1'b1, 16'h0009, 1'b0, '0);
    regs[64 +: 64] = mk_reg(16'h0009, 1'b1, 16'h0, 1'b0, '0);
    run("R4 R5 wide upper first", 32'h0009, 1'b1, regs, 3'b111, 1'b1);
    run("R5 narrow ignores upper", 32'h0009, 1'b0, regs, 3'b101, 1'b1);
    regs[0 +: 64] = mk_reg(16'h0009, 1'b1, 16'h0009, 1'b0, '0);
    run("R4 lower before upper", 32'h0009, 1'b1, regs, 3'b101, 1'b1);

    // R5: only an upper key matches, narrow mode -> miss
    regs = '0; regs[192 +: 64] = mk_reg(16'h0002, 1'b0, 16'h0033, 1'b0, '0);
    run("R5 R6 narrow upper only", 32'h0033, 1'b0, regs, 3'b000, 1'b0);
    run("R5 wide upper only", 32'h0033, 1'b1, regs, 3'b111, 1'b1);

    // R6: no match
    run("R6 miss", 32'h0044, 1'b1, regs, 3'b000, 1'b0);

    // R8: change inputs without a request
    run("R8 setup", 32'h0033, 1'b1, regs, 3'b111, 1'b1);
    @(negedge clk);
    access_id = 32'h0; pid_regs = '0; wide = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 hold without req", 3'b111, 1'b1, 1'b0);

    // Sweep over small keys (R2 R3 R4 R5 R6 R7)
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] aid;
      logic [3:0]  exp;
      logic        w;
      for (int r = 0; r < 4; r++)
        regs[r*64 +: 64] = mk_reg(16'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                                  16'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                                  {$urandom, $urandom});
      aid = 32'($urandom_range(0, 4));
      if ($urandom_range(0, 3) == 0) aid[20] = 1'b1;
      w = 1'($urandom_range(0, 1));
      exp = model(aid, w, regs);
      run("R2 R3 R4 R5 R6 R7 sweep", aid, w, regs, exp[2:0], exp[3]);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule